// File: doc/BRIEF.md
# Nonmaskable Interrupt Edge Detector and Acceptance Gate

This block turns one asynchronous nonmaskable interrupt pin into a request for a CPU exception unit. The pin is synchronised and compared with its previous sample. The edge that counts is rising or falling, chosen by a programmable polarity bit. A qualifying edge sets a sticky pending flag. The flag raises the accepted request whenever the acceptance condition is open, and it stays raised until the CPU acknowledges it.

Software writes three control bits: polarity, a global mask-all, and a block-mask-enable. When the polarity bit changes, the detector ignores edges for a fixed window, so that the switch itself cannot look like an edge. The request always carries the top priority level, 16. A one-cycle notify strobe marks the start of each acceptance. A separate output tells the rest of the interrupt logic to hold off every other source while the CPU's block bit and the block-mask-enable bit are both set. The block never drives any update of the CPU's interrupt mask level.

Top module: `nmi_gate`

## Requirements
- R1: After a synchronous reset, `nmi_req`, `nmi_notify` and `mask_others` are 0 and `nmi_level` is 0. The polarity resets to falling-edge (0), and mask-all and block-mask-enable both reset to 0.
- R2: With polarity 0, a 1-to-0 change of `nmi_pin` that is set up before clock edge k is seen as a falling edge. With acceptance open, `nmi_req` reads 1 after edge k+2.
- R3: With polarity 1, a 0-to-1 pin change is detected with the same latency as in R2. An edge of the opposite direction to the selected polarity is ignored.
- R4: A control write whose `ctl_edge_rise` differs from the current polarity blanks detection. An edge whose detection would fall in the 20 cycles after that write is ignored; the first edge detected after the window is taken. A further changing write during the window restarts it. A write of the same polarity value starts no window.
- R5: A detected edge sets the pending flag, and further edges while it is pending merge into it. `nmi_ack` clears it at the next clock edge, unless an edge is detected in that same cycle, in which case the flag stays set.
- R6: `nmi_req` equals pending AND (mask-all = 0) AND (block-mask-enable = 1 OR `sr_block` = 0 OR `sleep_mode` = 1). A pending request that the gate refuses is held, not dropped.
- R7: `nmi_level` reads 16 while `nmi_req` is 1 and 0 otherwise.
- R8: `nmi_notify` is high for exactly one cycle on each cycle where `nmi_req` goes from 0 to 1.
- R9: `mask_others` equals `sr_block` AND block-mask-enable.
- R10: A polarity change leaves an existing pending request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Asynchronous nonmaskable interrupt pin |
| ctl_we | input | 1 | Control write strobe |
| ctl_edge_rise | input | 1 | Written polarity: 1 rising, 0 falling |
| ctl_mask_all | input | 1 | Written mask-all bit |
| ctl_blk_en | input | 1 | Written block-mask-enable bit |
| sr_block | input | 1 | CPU status block bit |
| sleep_mode | input | 1 | CPU is in sleep or standby |
| nmi_ack | input | 1 | One-cycle acknowledge from the CPU |
| nmi_req | output | 1 | Accepted nonmaskable request |
| nmi_level | output | 5 | Priority level of the accepted request |
| nmi_notify | output | 1 | One-cycle acceptance strobe |
| mask_others | output | 1 | Holds off all other interrupt sources |

## Verification
The assertions assume that `nmi_ack` is a single-cycle pulse. They also assume that the control inputs are only read while `ctl_we` is high. The random stimulus raises acknowledge only in cycles where `nmi_req` is already high, and it drives control writes as isolated one-cycle strobes. It toggles the pin slowly enough that several edges fall inside blanking windows and several coincide with acknowledges.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    localparam int unsigned PRIO_W    = 5;
    localparam logic [PRIO_W-1:0] NMI_LEVEL = 5'd16;

    typedef struct packed {
        logic edge_rise;
        logic mask_all;
        logic blk_en;
    } nmi_ctl_t;

    function automatic logic edge_hit(input logic rise_mode, input logic cur, input logic old);
        return rise_mode ? (cur & ~old) : (~cur & old);
    endfunction

    function automatic logic gate_open(input logic mask_all, input logic blk_en,
                                       input logic sr_block, input logic sleep_mode);
        return ~mask_all & (blk_en | ~sr_block | sleep_mode);
    endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic cur,
    output logic old
);
    logic [STAGES-1:0] chain;
    logic              old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            old_q <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            old_q <= chain[STAGES-1];
        end
    end

    assign cur = chain[STAGES-1];
    assign old = old_q;
endmodule

// File: rtl/nmi_edge_blank.sv
module nmi_edge_blank #(
    parameter int unsigned BLANK_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_we,
    input  logic wr_rise,
    input  logic cur,
    input  logic old,
    output logic edge_rise,
    output logic det
);
    localparam int unsigned CNT_W = $clog2(BLANK_CYC + 1);

    logic [CNT_W-1:0] blank_cnt;
    logic             pol_change;

    assign pol_change = ctl_we && (wr_rise != edge_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_rise <= 1'b0;
            blank_cnt <= '0;
        end else begin
            if (ctl_we)
                edge_rise <= wr_rise;
            if (pol_change)
                blank_cnt <= CNT_W'(BLANK_CYC);
            else if (blank_cnt != '0)
                blank_cnt <= blank_cnt - CNT_W'(1);
        end
    end

    assign det = (blank_cnt == '0) && nmi_pkg::edge_hit(edge_rise, cur, old);

    AST_BLANK_RELOAD: assert property (@(posedge clk) disable iff (rst)
        pol_change |=> (blank_cnt == CNT_W'(BLANK_CYC))); // R4
    AST_SAME_POL_NO_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && !pol_change && blank_cnt == '0) |=> (blank_cnt == '0)); // R4
    AST_WINDOW_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (!pol_change && blank_cnt != '0) |=> (blank_cnt == $past(blank_cnt) - CNT_W'(1))); // R4
endmodule

// File: rtl/nmi_accept.sv
module nmi_accept
    import nmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              det,
    input  logic              ack,
    input  logic              ctl_we,
    input  logic              wr_mask_all,
    input  logic              wr_blk_en,
    input  logic              sr_block,
    input  logic              sleep_mode,
    output logic              nmi_req,
    output logic [PRIO_W-1:0] nmi_level,
    output logic              nmi_notify,
    output logic              mask_others
);
    logic mask_all, blk_en, pend, req_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_all <= 1'b0;
            blk_en   <= 1'b0;
            pend     <= 1'b0;
            req_d    <= 1'b0;
        end else begin
            if (ctl_we) begin
                mask_all <= wr_mask_all;
                blk_en   <= wr_blk_en;
            end
            pend  <= det | (pend & ~ack);
            req_d <= nmi_req;
        end
    end

    assign nmi_req     = pend & gate_open(mask_all, blk_en, sr_block, sleep_mode);
    assign nmi_notify  = nmi_req & ~req_d;
    assign mask_others = sr_block & blk_en;
    assign nmi_level   = nmi_req ? NMI_LEVEL : '0;

    AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        det |=> pend); // R5
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack) |=> pend); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && !det) |=> !pend); // R5
    AST_NOTIFY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        nmi_notify |=> !nmi_notify); // R8
    AST_NOTIFY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_req) |-> nmi_notify); // R8
    AST_MASK_ALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        mask_all |-> !nmi_req); // R6
endmodule

// File: rtl/nmi_gate.sv
module nmi_gate
    import nmi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BLANK_CYC   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_pin,
    input  logic              ctl_we,
    input  logic              ctl_edge_rise,
    input  logic              ctl_mask_all,
    input  logic              ctl_blk_en,
    input  logic              sr_block,
    input  logic              sleep_mode,
    input  logic              nmi_ack,
    output logic              nmi_req,
    output logic [PRIO_W-1:0] nmi_level,
    output logic              nmi_notify,
    output logic              mask_others
);
    nmi_ctl_t wr_ctl;
    logic     pin_cur, pin_old, edge_rise, det;

    assign wr_ctl = '{edge_rise: ctl_edge_rise, mask_all: ctl_mask_all, blk_en: ctl_blk_en};

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (nmi_pin),
        .cur (pin_cur),
        .old (pin_old)
    );

    nmi_edge_blank #(.BLANK_CYC(BLANK_CYC)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .wr_rise   (wr_ctl.edge_rise),
        .cur       (pin_cur),
        .old       (pin_old),
        .edge_rise (edge_rise),
        .det       (det)
    );

    nmi_accept u_acc (
        .clk         (clk),
        .rst         (rst),
        .det         (det),
        .ack         (nmi_ack),
        .ctl_we      (ctl_we),
        .wr_mask_all (wr_ctl.mask_all),
        .wr_blk_en   (wr_ctl.blk_en),
        .sr_block    (sr_block),
        .sleep_mode  (sleep_mode),
        .nmi_req     (nmi_req),
        .nmi_level   (nmi_level),
        .nmi_notify  (nmi_notify),
        .mask_others (mask_others)
    );

    AST_OPPOSITE_EDGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (edge_rise ? (!pin_cur && pin_old) : (pin_cur && !pin_old)) |-> !det); // R3
    AST_LEVEL_TOP: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> (nmi_level == 5'd16)); // R7
endmodule

// File: tb/nmi_gate_bench.sv
`timescale 1ns/1ps
module nmi_gate_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_pin = 1'b0, ctl_we = 1'b0, ctl_edge_rise = 1'b0, ctl_mask_all = 1'b0, ctl_blk_en = 1'b0;
    logic sr_block = 1'b0, sleep_mode = 1'b0, nmi_ack = 1'b0;
    logic nmi_req, nmi_notify, mask_others;
    logic [4:0] nmi_level;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nmi_gate u_nmi_gate (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .ctl_we(ctl_we),
        .ctl_edge_rise(ctl_edge_rise), .ctl_mask_all(ctl_mask_all), .ctl_blk_en(ctl_blk_en),
        .sr_block(sr_block), .sleep_mode(sleep_mode), .nmi_ack(nmi_ack),
        .nmi_req(nmi_req), .nmi_level(nmi_level), .nmi_notify(nmi_notify), .mask_others(mask_others)
    );

    // Reference model built from the requirements
    logic m_s1 = 0, m_s2 = 0, m_old = 0, m_rise = 0, m_mall = 0, m_blk = 0, m_pend = 0, m_reqd = 0;
    int   m_cnt = 0;

    function automatic logic mdl_req();
        return m_pend && !m_mall && (m_blk || !sr_block || sleep_mode);
    endfunction

    function automatic logic mdl_det();
        if (m_cnt != 0) return 1'b0;
        return m_rise ? (m_s2 && !m_old) : (!m_s2 && m_old);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_old <= 0; m_rise <= 0; m_mall <= 0;
            m_blk <= 0; m_pend <= 0; m_reqd <= 0; m_cnt <= 0;
        end else begin
            m_pend <= mdl_det() || (m_pend && !nmi_ack);
            m_reqd <= mdl_req();
            m_s1 <= nmi_pin; m_s2 <= m_s1; m_old <= m_s2;
            if (ctl_we) begin
                m_rise <= ctl_edge_rise; m_mall <= ctl_mask_all; m_blk <= ctl_blk_en;
            end
            if (ctl_we && ctl_edge_rise != m_rise) m_cnt <= 20;
            else if (m_cnt != 0) m_cnt <= m_cnt - 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check("R6 req vs model", nmi_req, mdl_req());
        check("R7 level vs model", nmi_level, mdl_req() ? 32'd16 : 32'd0);
        check("R8 notify vs model", nmi_notify, mdl_req() && !m_reqd);
        check("R9 suppress vs model", mask_others, sr_block && m_blk);
    endtask

    task automatic wr_ctl(input logic r, input logic ma, input logic be);
        ctl_we = 1; ctl_edge_rise = r; ctl_mask_all = ma; ctl_blk_en = be;
        cyc();
        ctl_we = 0;
    endtask

    task automatic do_ack();
        nmi_ack = 1; cyc(); nmi_ack = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) cyc();
        rst = 0;
        cyc();
        check("R1 req after reset", nmi_req, 0);
        check("R1 level after reset", nmi_level, 0);
        check("R1 notify after reset", nmi_notify, 0);
        check("R1 suppress after reset", mask_others, 0);

        nmi_pin = 1; repeat (4) cyc();
        check("R3 rising ignored in falling mode", nmi_req, 0);
        nmi_pin = 0;
        cyc(); check("R2 latency edge+1", nmi_req, 0);
        cyc(); check("R2 latency edge+2", nmi_req, 0);
        cyc(); check("R2 falling edge accepted", nmi_req, 1);
        check("R7 level 16", nmi_level, 16);
        check("R8 notify first cycle", nmi_notify, 1);
        cyc(); check("R8 notify single", nmi_notify, 0);
        check("R5 held until ack", nmi_req, 1);
        do_ack(); check("R5 ack clears", nmi_req, 0);

        nmi_pin = 1; cyc(); nmi_pin = 0; repeat (3) cyc();
        check("R5 first edge pending", nmi_req, 1);
        nmi_pin = 1; cyc(); nmi_pin = 0; repeat (4) cyc();
        do_ack(); check("R5 merged edge cleared by one ack", nmi_req, 0);

        wr_ctl(0, 0, 0);
        nmi_pin = 1; cyc(); nmi_pin = 0; repeat (3) cyc();
        check("R4 same-value write opens no window", nmi_req, 1);
        do_ack();

        wr_ctl(1, 0, 0); repeat (17) cyc(); nmi_pin = 1; repeat (6) cyc();
        check("R4 edge at window end ignored", nmi_req, 0);
        wr_ctl(0, 0, 0); repeat (18) cyc(); nmi_pin = 0; repeat (3) cyc();
        check("R4 first edge after window taken", nmi_req, 1);
        do_ack();

        nmi_pin = 1; repeat (5) cyc();
        wr_ctl(1, 0, 0); repeat (10) cyc(); wr_ctl(0, 0, 0);
        repeat (12) cyc(); nmi_pin = 0; repeat (5) cyc();
        check("R4 restarted window blanks edge", nmi_req, 0);
        repeat (20) cyc();

        wr_ctl(0, 1, 0);
        nmi_pin = 1; cyc(); nmi_pin = 0; repeat (4) cyc();
        check("R6 mask-all holds request off", nmi_req, 0);
        wr_ctl(1, 1, 0); cyc();
        check("R6 still masked", nmi_req, 0);
        wr_ctl(1, 0, 0);
        check("R10 pending survives polarity change", nmi_req, 1);
        check("R8 notify on unmask", nmi_notify, 1);
        do_ack();

        repeat (25) cyc();
        sr_block = 1; nmi_pin = 1; repeat (4) cyc();
        check("R6 block bit refuses", nmi_req, 0);
        check("R9 suppress off without enable", mask_others, 0);
        sleep_mode = 1; cyc();
        check("R6 sleep overrides block bit", nmi_req, 1);
        sleep_mode = 0; wr_ctl(1, 0, 1);
        check("R6 block-mask-enable admits", nmi_req, 1);
        check("R9 suppress others", mask_others, 1);
        do_ack();
        sr_block = 0; wr_ctl(1, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            cyc();
            nmi_ack = nmi_req && ($urandom % 3 == 0);
            if ($urandom % 6 == 0) nmi_pin = ~nmi_pin;
            ctl_we = ($urandom % 40 == 0);
            ctl_edge_rise = $urandom % 2;
            ctl_mask_all  = ($urandom % 4 == 0);
            ctl_blk_en    = $urandom % 2;
            sr_block      = $urandom % 2;
            sleep_mode    = ($urandom % 5 == 0);
        end
        cyc();
        done = 1;
        summary();
    end
endmodule